// File: doc/BRIEF.md
# Two-Point Linear Temperature Calibrator

This block converts raw 9-bit codes from a time-domain temperature sensor into signed fixed-point temperatures. The sensor code is treated as a straight-line function of temperature, so the block learns that line during calibration. In two-point mode it captures a code with the die held at 20 °C and another at 80 °C. From the two codes it derives a gain and a reference point. In one-point mode it assumes the line passes through zero and uses one capture taken at 50 °C. After calibration every new code goes through the inverse linear map. The result has 4 fractional bits, finer than the roughly 0.49 °C that one code step stands for.

The gain comes from a serial divider that takes one quotient bit per clock. While the divider runs, a busy flag is high and incoming codes are dropped. A capture with a zero divisor raises a calibration error and leaves the previous coefficients unchanged. This happens when the two codes are equal, or when a one-point capture reads zero. Results outside 0 to 100 °C are still delivered, with an out-of-range flag set.

Top module: `temp_cal2pt`

## Requirements
- R1: After reset, temp_vld_o, busy_o and cal_err_o are low. The coefficients map a code X to temp_o = 16·X, which is one degree per code.
- R2: Two-point conversion. Let L and H be the 20 °C and 80 °C codes, and let G = sign(H−L)·floor(3932160/|H−L|). Then temp_o = 320 + floor((X−L)·G/4096), with the floor taken toward minus infinity.
- R3: One-point conversion uses the 50 °C code C, with G = floor(3276800/C). Then temp_o = floor(X·G/4096), so the offset is zero.
- R4: temp_vld_o pulses exactly 3 cycles after each code that is accepted for conversion. Back-to-back codes produce back-to-back results in order.
- R5: A capture command (cap_req_i, with cap_hi_i choosing 80 °C over 20 °C and one_pt_i choosing one-point mode) takes the first valid code strictly after the command cycle. That captured code gives no output. A code in the same cycle as the command is converted normally.
- R6: A 80 °C capture or a one-point capture with a non-zero divisor raises busy_o from the next cycle, for exactly 22 cycles. Codes that arrive while busy_o is high give no output and are not captured.
- R7: A capture whose divisor is zero (H equal to L, or C equal to 0) sets cal_err_o from the next cycle. In that case busy_o stays low and conversions keep the previous coefficients. The next derivation that succeeds clears cal_err_o.
- R8: oor_o is high together with temp_vld_o when the result is below 0 or above 1600 (100 °C). The value is still delivered.
- R9: A falling line, where H is below L, gives a negative gain and correct conversions.
- R10: Results beyond the 16-bit signed range saturate to 32767 or −32768.
- R11: A 20 °C capture on its own starts no derivation. It leaves busy_o low and leaves conversions unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| code_i | input | 9 | Raw sensor code |
| code_vld_i | input | 1 | code_i is valid this cycle |
| cap_req_i | input | 1 | Arm a capture for the next valid code |
| cap_hi_i | input | 1 | Two-point capture selects 80 °C (1) or 20 °C (0) |
| one_pt_i | input | 1 | Capture is a one-point 50 °C capture |
| temp_o | output | 16 | Signed temperature, 4 fractional bits |
| temp_vld_o | output | 1 | temp_o is valid |
| oor_o | output | 1 | Result lies outside 0 to 100 °C |
| busy_o | output | 1 | Gain derivation running; codes are dropped |
| cal_err_o | output | 1 | Last derivation attempt had a zero divisor |

## Verification
The hardest cases are the ones that happen inside the divider's busy window. A code must arrive during that window and be dropped, and the coefficients must switch at the exact edge where busy falls. The stimulus gets there by injecting a code a few cycles into each derivation. It then converts codes straight after busy falls and checks them against the new gain. Saturation needs extreme gains, which come from a pair of adjacent captured codes. A zero-divisor capture made after a falling-line calibration shows that the previous coefficients are still in use.

// File: rtl/tcal_pkg.sv
package tcal_pkg;

  // pending capture request, latched when the command is issued
  typedef struct packed {
    logic armed;
    logic one_pt;
    logic sel_hi;
  } arm_t;

  localparam arm_t ARM_IDLE = '{armed: 1'b0, one_pt: 1'b0, sel_hi: 1'b0};

endpackage

// File: rtl/tcal_seq_div.sv
module tcal_seq_div #(
  parameter int NUM_W = 22,
  parameter int DEN_W = 9
) (
  input  logic             clk,
  input  logic             rsn,
  input  logic             start_i,
  input  logic [NUM_W-1:0] num_i,
  input  logic [DEN_W-1:0] den_i,
  output logic             busy_o,
  output logic             done_o,
  output logic [NUM_W-1:0] quot_o
);
  localparam int CNT_W = $clog2(NUM_W + 1);

  logic             busy_q, busy_n;
  logic [CNT_W-1:0] cnt_q, cnt_n;
  logic [DEN_W-1:0] rem_q, rem_n;
  logic [NUM_W-1:0] sh_q, sh_n;
  logic [DEN_W-1:0] den_q, den_n;

  logic [DEN_W:0]   rem_sh, rem_sub;
  logic             ge;
  logic [DEN_W-1:0] rem_step;
  logic [NUM_W-1:0] sh_step;

  // one restoring step: shift a numerator bit in, subtract when possible
  always_comb begin
    rem_sh   = {rem_q, sh_q[NUM_W-1]};
    rem_sub  = rem_sh - {1'b0, den_q};
    ge       = (rem_sh >= {1'b0, den_q});
    rem_step = ge ? rem_sub[DEN_W-1:0] : rem_sh[DEN_W-1:0];
    sh_step  = {sh_q[NUM_W-2:0], ge};
  end

  always_comb begin
    busy_n = busy_q;
    cnt_n  = cnt_q;
    rem_n  = rem_q;
    sh_n   = sh_q;
    den_n  = den_q;
    if (start_i) begin
      busy_n = 1'b1;
      cnt_n  = CNT_W'(NUM_W);
      rem_n  = '0;
      sh_n   = num_i;
      den_n  = den_i;
    end else if (busy_q) begin
      rem_n = rem_step;
      sh_n  = sh_step;
      cnt_n = cnt_q - 1'b1;
      if (cnt_q == CNT_W'(1)) busy_n = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rsn) begin
    if (!rsn) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
      rem_q  <= '0;
      sh_q   <= '0;
      den_q  <= '0;
    end else begin
      busy_q <= busy_n;
      cnt_q  <= cnt_n;
      rem_q  <= rem_n;
      sh_q   <= sh_n;
      den_q  <= den_n;
    end
  end

  assign busy_o = busy_q;
  assign done_o = busy_q && (cnt_q == CNT_W'(1));
  assign quot_o = sh_step;

  // R6
  start_idle_chk: assert property (@(posedge clk) disable iff (!rsn)
    start_i |-> !busy_q);

  // R2
  rem_bound_chk: assert property (@(posedge clk) disable iff (!rsn)
    done_o |-> (rem_step < den_q));

endmodule

// File: rtl/tcal_ctrl.sv
module tcal_ctrl
  import tcal_pkg::*;
#(
  parameter int CODE_W    = 9,
  parameter int FRAC_W    = 4,
  parameter int GAIN_FRAC = 12,
  parameter int OUT_W     = 16,
  parameter int NUM_W     = 22,
  parameter int T_LO      = 20,
  parameter int T_HI      = 80,
  parameter int T_ONE     = 50
) (
  input  logic                    clk,
  input  logic                    rsn,
  input  logic [CODE_W-1:0]       code_i,
  input  logic                    code_vld_i,
  input  logic                    cap_req_i,
  input  logic                    cap_hi_i,
  input  logic                    one_pt_i,
  input  logic                    div_busy_i,
  input  logic                    div_done_i,
  input  logic [NUM_W-1:0]        div_quot_i,
  output logic                    div_start_o,
  output logic [NUM_W-1:0]        div_num_o,
  output logic [CODE_W-1:0]       div_den_o,
  output logic                    conv_vld_o,
  output logic signed [NUM_W:0]   gain_o,
  output logic [CODE_W-1:0]       xref_o,
  output logic signed [OUT_W-1:0] tref_o,
  output logic                    cal_err_o
);
  localparam int G_W = NUM_W + 1;
  localparam int D_W = CODE_W + 1;
  localparam logic [NUM_W-1:0] NUM_TWO = NUM_W'((T_HI - T_LO) << (FRAC_W + GAIN_FRAC));
  localparam logic [NUM_W-1:0] NUM_ONE = NUM_W'(T_ONE << (FRAC_W + GAIN_FRAC));
  localparam logic signed [G_W-1:0] GAIN_RST = G_W'(1) << (FRAC_W + GAIN_FRAC);
  localparam logic signed [OUT_W-1:0] TREF_TWO = OUT_W'(T_LO << FRAC_W);

  arm_t                    arm_q, arm_n;
  logic [CODE_W-1:0]       xlo_q, xlo_n;
  logic                    pneg_q, pneg_n;
  logic [CODE_W-1:0]       pxr_q, pxr_n;
  logic signed [OUT_W-1:0] ptr_q, ptr_n;
  logic signed [G_W-1:0]   gain_q, gain_n;
  logic [CODE_W-1:0]       xr_q, xr_n;
  logic signed [OUT_W-1:0] tr_q, tr_n;
  logic                    err_q, err_n;

  logic                    accept, take, launch, zero;
  logic signed [D_W-1:0]   diff, mag;
  logic signed [G_W-1:0]   gq;

  always_comb begin
    accept = code_vld_i && !div_busy_i;
    take   = accept && arm_q.armed;
    launch = take && (arm_q.one_pt || arm_q.sel_hi);
    if (arm_q.one_pt) diff = $signed({1'b0, code_i});
    else              diff = $signed({1'b0, code_i}) - $signed({1'b0, xlo_q});
    mag    = diff[D_W-1] ? -diff : diff;
    zero   = (diff == '0);
    gq     = $signed({1'b0, div_quot_i});
  end

  assign conv_vld_o  = accept && !arm_q.armed;
  assign div_start_o = launch && !zero;
  assign div_num_o   = arm_q.one_pt ? NUM_ONE : NUM_TWO;
  assign div_den_o   = mag[CODE_W-1:0];

  always_comb begin
    arm_n  = arm_q;
    xlo_n  = xlo_q;
    pneg_n = pneg_q;
    pxr_n  = pxr_q;
    ptr_n  = ptr_q;
    gain_n = gain_q;
    xr_n   = xr_q;
    tr_n   = tr_q;
    err_n  = err_q;
    if (take) arm_n.armed = 1'b0;
    if (cap_req_i) arm_n = '{armed: 1'b1, one_pt: one_pt_i, sel_hi: cap_hi_i};
    if (take && !arm_q.one_pt && !arm_q.sel_hi) xlo_n = code_i;
    if (launch) begin
      err_n = zero;
      if (!zero) begin
        pneg_n = diff[D_W-1];
        pxr_n  = arm_q.one_pt ? '0 : xlo_q;
        ptr_n  = arm_q.one_pt ? '0 : TREF_TWO;
      end
    end
    if (div_done_i) begin
      gain_n = pneg_q ? -gq : gq;
      xr_n   = pxr_q;
      tr_n   = ptr_q;
    end
  end

  always_ff @(posedge clk or negedge rsn) begin
    if (!rsn) begin
      arm_q  <= ARM_IDLE;
      xlo_q  <= '0;
      pneg_q <= 1'b0;
      pxr_q  <= '0;
      ptr_q  <= '0;
      gain_q <= GAIN_RST;
      xr_q   <= '0;
      tr_q   <= '0;
      err_q  <= 1'b0;
    end else begin
      arm_q  <= arm_n;
      xlo_q  <= xlo_n;
      pneg_q <= pneg_n;
      pxr_q  <= pxr_n;
      ptr_q  <= ptr_n;
      gain_q <= gain_n;
      xr_q   <= xr_n;
      tr_q   <= tr_n;
      err_q  <= err_n;
    end
  end

  assign gain_o    = gain_q;
  assign xref_o    = xr_q;
  assign tref_o    = tr_q;
  assign cal_err_o = err_q;

  // R7
  err_no_busy_chk: assert property (@(posedge clk) disable iff (!rsn)
    err_q |-> !div_busy_i);

  // R11
  gain_hold_chk: assert property (@(posedge clk) disable iff (!rsn)
    !div_busy_i |=> $stable(gain_q));

endmodule

// File: rtl/tcal_map.sv
module tcal_map #(
  parameter int CODE_W    = 9,
  parameter int FRAC_W    = 4,
  parameter int GAIN_FRAC = 12,
  parameter int OUT_W     = 16,
  parameter int G_W       = 23,
  parameter int T_MAX     = 100
) (
  input  logic                    clk,
  input  logic                    rsn,
  input  logic                    vld_i,
  input  logic [CODE_W-1:0]       code_i,
  input  logic signed [G_W-1:0]   gain_i,
  input  logic [CODE_W-1:0]       xref_i,
  input  logic signed [OUT_W-1:0] tref_i,
  output logic signed [OUT_W-1:0] temp_o,
  output logic                    vld_o,
  output logic                    oor_o
);
  localparam int D_W = CODE_W + 1;
  localparam int P_W = D_W + G_W;
  localparam int S_W = P_W + 1;
  localparam logic signed [S_W-1:0] SAT_HI = S_W'((1 << (OUT_W - 1)) - 1);
  localparam logic signed [S_W-1:0] SAT_LO = -SAT_HI - S_W'(1);
  localparam logic signed [S_W-1:0] LIM_HI = S_W'(T_MAX << FRAC_W);

  logic                    v1_q, v2_q, v3_q;
  logic signed [D_W-1:0]   d1_q, d1_n;
  logic signed [P_W-1:0]   p2_q, p2_n;
  logic signed [OUT_W-1:0] t3_q, t3_n;
  logic                    o3_q, o3_n;
  logic signed [P_W-1:0]   shifted;
  logic signed [S_W-1:0]   sum;

  always_comb begin
    d1_n    = $signed({1'b0, code_i}) - $signed({1'b0, xref_i});
    p2_n    = P_W'(d1_q) * P_W'(gain_i);
    shifted = p2_q >>> GAIN_FRAC;
    sum     = S_W'(shifted) + S_W'(tref_i);
    o3_n    = (sum < 0) || (sum > LIM_HI);
    if (sum > SAT_HI)      t3_n = OUT_W'(SAT_HI);
    else if (sum < SAT_LO) t3_n = OUT_W'(SAT_LO);
    else                   t3_n = sum[OUT_W-1:0];
  end

  always_ff @(posedge clk or negedge rsn) begin
    if (!rsn) begin
      v1_q <= 1'b0;
      v2_q <= 1'b0;
      v3_q <= 1'b0;
      d1_q <= '0;
      p2_q <= '0;
      t3_q <= '0;
      o3_q <= 1'b0;
    end else begin
      v1_q <= vld_i;
      v2_q <= v1_q;
      v3_q <= v2_q;
      if (vld_i) d1_q <= d1_n;
      if (v1_q)  p2_q <= p2_n;
      if (v2_q) begin
        t3_q <= t3_n;
        o3_q <= o3_n;
      end
    end
  end

  assign temp_o = t3_q;
  assign vld_o  = v3_q;
  assign oor_o  = v3_q && o3_q;

  // R4
  lat_three_chk: assert property (@(posedge clk) disable iff (!rsn)
    vld_o |-> $past(vld_i, 3));

  // R8
  in_range_chk: assert property (@(posedge clk) disable iff (!rsn)
    (vld_o && !oor_o) |-> (temp_o >= 0 && temp_o <= OUT_W'(T_MAX << FRAC_W)));

endmodule

// File: rtl/temp_cal2pt.sv
module temp_cal2pt #(
  parameter int CODE_W    = 9,
  parameter int FRAC_W    = 4,
  parameter int GAIN_FRAC = 12,
  parameter int OUT_W     = 16,
  parameter int T_LO      = 20,
  parameter int T_HI      = 80,
  parameter int T_ONE     = 50,
  parameter int T_MAX     = 100
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CODE_W-1:0] code_i,
  input  logic              code_vld_i,
  input  logic              cap_req_i,
  input  logic              cap_hi_i,
  input  logic              one_pt_i,
  output logic [OUT_W-1:0]  temp_o,
  output logic              temp_vld_o,
  output logic              oor_o,
  output logic              busy_o,
  output logic              cal_err_o
);
  localparam int SPAN_MAX = ((T_HI - T_LO) > T_ONE) ? (T_HI - T_LO) : T_ONE;
  localparam int TW       = $clog2(SPAN_MAX + 1);
  localparam int NUM_W    = TW + FRAC_W + GAIN_FRAC;
  localparam int G_W      = NUM_W + 1;

  logic [1:0] rs_q;
  logic       rsn;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rsn = rs_q[1];

  logic                    div_start, div_busy, div_done;
  logic [NUM_W-1:0]        div_num, div_quot;
  logic [CODE_W-1:0]       div_den;
  logic                    conv_vld;
  logic signed [G_W-1:0]   gain;
  logic [CODE_W-1:0]       xref;
  logic signed [OUT_W-1:0] tref, temp_s;

  tcal_ctrl #(
    .CODE_W(CODE_W), .FRAC_W(FRAC_W), .GAIN_FRAC(GAIN_FRAC), .OUT_W(OUT_W),
    .NUM_W(NUM_W), .T_LO(T_LO), .T_HI(T_HI), .T_ONE(T_ONE)
  ) u_ctrl (
    .clk(clk), .rsn(rsn), .code_i(code_i), .code_vld_i(code_vld_i),
    .cap_req_i(cap_req_i), .cap_hi_i(cap_hi_i), .one_pt_i(one_pt_i),
    .div_busy_i(div_busy), .div_done_i(div_done), .div_quot_i(div_quot),
    .div_start_o(div_start), .div_num_o(div_num), .div_den_o(div_den),
    .conv_vld_o(conv_vld), .gain_o(gain), .xref_o(xref), .tref_o(tref),
    .cal_err_o(cal_err_o)
  );

  tcal_seq_div #(.NUM_W(NUM_W), .DEN_W(CODE_W)) u_div (
    .clk(clk), .rsn(rsn), .start_i(div_start), .num_i(div_num), .den_i(div_den),
    .busy_o(div_busy), .done_o(div_done), .quot_o(div_quot)
  );

  tcal_map #(
    .CODE_W(CODE_W), .FRAC_W(FRAC_W), .GAIN_FRAC(GAIN_FRAC), .OUT_W(OUT_W),
    .G_W(G_W), .T_MAX(T_MAX)
  ) u_map (
    .clk(clk), .rsn(rsn), .vld_i(conv_vld), .code_i(code_i), .gain_i(gain),
    .xref_i(xref), .tref_i(tref), .temp_o(temp_s), .vld_o(temp_vld_o), .oor_o(oor_o)
  );

  assign temp_o = temp_s;
  assign busy_o = div_busy;

  // R6
  no_out_busy_chk: assert property (@(posedge clk) disable iff (!rsn)
    temp_vld_o |-> !$past(busy_o, 3));

  // R8
  oor_qual_chk: assert property (@(posedge clk) disable iff (!rsn)
    oor_o |-> temp_vld_o);

endmodule

// File: tb/temp_cal2pt_tb.sv
module temp_cal2pt_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [8:0]  code_i = '0;
  logic        code_vld_i = 1'b0;
  logic        cap_req_i = 1'b0;
  logic        cap_hi_i = 1'b0;
  logic        one_pt_i = 1'b0;
  logic [15:0] temp_o;
  logic        temp_vld_o, oor_o, busy_o, cal_err_o;

  always #2.5 clk = ~clk;

  temp_cal2pt u_dut (
    .clk(clk), .rst_n(rst_n), .code_i(code_i), .code_vld_i(code_vld_i),
    .cap_req_i(cap_req_i), .cap_hi_i(cap_hi_i), .one_pt_i(one_pt_i),
    .temp_o(temp_o), .temp_vld_o(temp_vld_o), .oor_o(oor_o),
    .busy_o(busy_o), .cal_err_o(cal_err_o)
  );

  typedef struct { int val; bit oor; int due; string tag; } exp_t;
  exp_t sbq[$];

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit finished = 0;

  // bench model of the coefficients
  longint mg = 65536;
  longint mxr = 0;
  longint mtr = 0;
  int     mlo = 0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string tag, input longint act, input longint expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
    end
  endtask

  task automatic conv(input int x, input string tag);
    exp_t e;
    longint s;
    s = mtr + (((longint'(x) - mxr) * mg) >>> 12);
    e.oor = (s < 0) || (s > 1600);
    if (s > 32767) s = 32767;
    if (s < -32768) s = -32768;
    e.val = int'(s);
    e.due = cyc + 3;
    e.tag = tag;
    code_i = 9'(x);
    code_vld_i = 1'b1;
    sbq.push_back(e);
    @(negedge clk);
    code_vld_i = 1'b0;
  endtask

  task automatic cap(input bit one, input bit hi, input int x, input string tag);
    longint d, n;
    bit launch, zero;
    int nb;
    cap_req_i = 1'b1; one_pt_i = one; cap_hi_i = hi;
    @(negedge clk);
    cap_req_i = 1'b0;
    code_i = 9'(x); code_vld_i = 1'b1;
    @(negedge clk);
    code_vld_i = 1'b0;
    launch = one || hi;
    d = one ? longint'(x) : longint'(x) - mlo;
    zero = launch && (d == 0);
    if (!launch) begin
      mlo = x;
      chk(busy_o == 1'b0, {tag, " R11 no busy after low capture"}, busy_o, 0);
      return;
    end
    chk(cal_err_o == zero, {tag, " R7 cal_err_o"}, cal_err_o, zero);
    if (zero) begin
      chk(busy_o == 1'b0, {tag, " R7 busy stays low"}, busy_o, 0);
      return;
    end
    nb = 0;
    while (busy_o) begin
      nb++;
      code_vld_i = (nb == 5);
      code_i = 9'd77;
      @(negedge clk);
    end
    code_vld_i = 1'b0;
    chk(nb == 22, {tag, " R6 busy length"}, nb, 22);
    n = one ? 64'd3276800 : 64'd3932160;
    mg = (d < 0) ? -(n / -d) : n / d;
    mxr = one ? 0 : mlo;
    mtr = one ? 0 : 320;
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n && temp_vld_o && !finished) begin
      if (sbq.size() == 0) begin
        chk(1'b0, "R4/R6 unexpected output", $signed(temp_o), 0);
      end else begin
        exp_t e;
        e = sbq.pop_front();
        chk($signed(temp_o) == e.val, {e.tag, " temp_o"}, $signed(temp_o), e.val);
        chk(oor_o == e.oor, {e.tag, " R8 oor_o"}, oor_o, e.oor);
        chk(cyc == e.due, {e.tag, " R4 latency"}, cyc, e.due);
      end
    end
  end

  task automatic summary;
    if (!finished) begin
      finished = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R1 reset state
    chk(temp_vld_o == 0, "R1 temp_vld_o", temp_vld_o, 0);
    chk(busy_o == 0, "R1 busy_o", busy_o, 0);
    chk(cal_err_o == 0, "R1 cal_err_o", cal_err_o, 0);
    conv(37, "R1 default");
    conv(0, "R1 default zero");
    conv(511, "R1 R8 default top");
    conv(200, "R4 back-to-back");
    repeat (5) @(negedge clk);

    // two-point rising line
    cap(0, 0, 100, "R11 lo");
    conv(150, "R11 unchanged map");
    repeat (4) @(negedge clk);
    cap(0, 1, 400, "R2 hi");
    conv(100, "R2 at low point");
    conv(400, "R2 at high point");
    conv(250, "R2 mid");
    conv(50, "R2 R8 below");
    conv(500, "R2 R8 above");
    repeat (5) @(negedge clk);

    // R5: code in the command cycle is converted, next code captured
    cap_req_i = 1'b1; cap_hi_i = 1'b0; one_pt_i = 1'b0;
    conv(120, "R5 same-cycle code");
    cap_req_i = 1'b0;
    code_i = 9'd300; code_vld_i = 1'b1;
    @(negedge clk);
    code_vld_i = 1'b0;
    mlo = 300;
    repeat (5) @(negedge clk);
    chk(sbq.size() == 0, "R5 captured code gave no output", sbq.size(), 0);

    // R9 falling line
    cap(0, 1, 200, "R9 hi");
    conv(250, "R9 mid");
    conv(300, "R9 low point");
    conv(180, "R9 beyond");
    repeat (5) @(negedge clk);

    // R7 equal codes keep previous coefficients
    cap(0, 0, 200, "R7 lo");
    cap(0, 1, 200, "R7 hi equal");
    conv(250, "R7 old map kept");
    repeat (5) @(negedge clk);
    cap(0, 1, 260, "R7 recover");
    chk(cal_err_o == 0, "R7 error cleared", cal_err_o, 0);
    conv(230, "R7 new map");
    repeat (5) @(negedge clk);

    // R3 one-point
    cap(1, 0, 250, "R3 one");
    conv(250, "R3 at point");
    conv(0, "R3 zero");
    conv(100, "R3 low");
    repeat (5) @(negedge clk);
    cap(1, 0, 0, "R7 one zero");
    conv(125, "R7 one-point kept");
    repeat (5) @(negedge clk);

    // R10 saturation
    cap(0, 0, 100, "R10 lo");
    cap(0, 1, 101, "R10 hi");
    conv(0, "R10 negative saturation");
    conv(511, "R10 positive saturation");
    conv(101, "R10 near");
    repeat (8) @(negedge clk);
    chk(sbq.size() == 0, "R4 all results delivered", sbq.size(), 0);
    summary();
  end
endmodule